// File: doc/BRIEF.md
# Hot-Plug Slot Command and Event Controller

This block keeps the slot control word and the slot status word of a hot-plug capable downstream port. It watches configuration writes. A write that reaches the control word is treated as a slot command. The block acts on the command within one cycle and sets the command-completed flag, so software never waits for a command to finish. Hardware event inputs set the flags of the status word, and software clears those flags by writing ones to them.

The two 16-bit words share one dword at a configurable dword address. The control word sits in bytes 0–1 and the status word in bytes 2–3. Both words are always visible on a read bus. The block drives an electromechanical interlock state and an interrupt in one of two forms, picked by an input that says whether message-signalled interrupts are on. When they are on, it sends a one-cycle request pulse on an edge-like condition. When they are off, it holds a legacy wire-interrupt level that tracks the enabled, pending flags.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, both words read as zero, and interlock_state, intx_level and msi_req are 0.
- R2: A write is a slot command only when cfg_wr_en is 1, the address equals SLOT_DWORD, and byte enable 0 or 1 is set. Any other write leaves the control word and the command-completed flag unchanged.
- R3: rd_data[15:0] is the control word and rd_data[31:16] is the status word. Control bits: enables for attention button, power fault, sensor change, presence change and command completed at 0..4, hot-plug interrupt enable at 5. Status flags 0..4 match those enables, and the interlock state is at status bit 7. A command with byte enable 0 loads control bits 5:0 from data[5:0]. All other bits read 0.
- R4: A command with byte enable 1 and data bit 11 set toggles the interlock state (status bit 7, also on interlock_state). Control bit 11 always reads 0.
- R5: Every slot command sets status bit 4 at the next clock edge, even a command that changes nothing.
- R6: A matching write with byte enable 2 clears each status flag 0..4 whose data bit 16+i is 1. If a flag is set and cleared in the same cycle, the set wins. Status bit 7 is not writable.
- R7: hw_evt[i] (i = 0..3) set at a clock edge sets status flag i.
- R8: With msi_enable = 1, msi_req is high for the cycle after a command when the hot-plug enable is set after the command and some enable went from 0 to 1 while its flag was already set.
- R9: With msi_enable = 1, a command that leaves the command-completed enable and the hot-plug enable set raises msi_req in the following cycle.
- R10: With msi_enable = 0, msi_req stays 0 and intx_level equals hot-plug enable AND the OR over i of (enable i AND flag i). With msi_enable = 1, intx_level is 0.
- R11: With msi_enable = 1, a hardware event that moves flag i from 0 to 1 while enable i and the hot-plug enable are set raises msi_req in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | ADDR_W | Dword address of the write |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| msi_enable | input | 1 | Message-signalled interrupts selected |
| hw_evt | input | 4 | Event set pulses: attention button, power fault, sensor change, presence change |
| rd_data | output | 32 | Status word (upper half) and control word (lower half) |
| interlock_state | output | 1 | Electromechanical interlock engaged |
| intx_level | output | 1 | Wire-interrupt level |
| msi_req | output | 1 | One-cycle message interrupt request |

## Verification
The bench builds the block with ADDR_W = 10 and SLOT_DWORD = 0x16. This lets random writes fall on the slot dword, on its neighbour and anywhere else in a 1024-dword space, so address-miss filtering is exercised as often as hits. Directed cases cover the byte-lane split: a status-only write that must not count as a command, interlock toggles with the control low byte left alone, and a set racing a clear. The bench also walks the enable-rising and hardware-event paths of the message interrupt, together with cases where no pulse is due.

// File: rtl/hp_slot_pkg.sv
`timescale 1ns/1ps
package hp_slot_pkg;
  localparam int FLAG_W   = 5;   // status flags 0..4 with matching enables
  localparam int HW_EVT_W = 4;   // flags 0..3 come from hardware events
  localparam int CC_BIT   = 4;   // command completed flag / enable
  localparam int ILK_BIT  = 11;  // interlock control bit in control word
  localparam int STS_OFS  = 16;  // status word offset in the dword
  localparam int BE_CTL_LO = 0;
  localparam int BE_CTL_HI = 1;
  localparam int BE_STS_LO = 2;

  typedef struct packed {
    logic              hpie;
    logic [FLAG_W-1:0] en;
  } ctl_t;

  typedef struct packed {
    logic              ilk;
    logic [FLAG_W-1:0] flag;
  } sts_t;
endpackage

// File: rtl/hp_rst_sync.sv
`timescale 1ns/1ps
module hp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/hp_cfg_decode.sv
`timescale 1ns/1ps
module hp_cfg_decode
  import hp_slot_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int unsigned SLOT_DWORD = 32'h16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic              cmd,
  output logic              ctl_we,
  output ctl_t              ctl_wval,
  output logic              ilk_toggle,
  output logic [FLAG_W-1:0] sts_w1c
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SLOT_DWORD);

  logic hit;
  logic unused_bits;

  always_comb begin
    hit         = wr_en && (wr_addr == MATCH);
    // any byte of the control word makes the whole write one command
    cmd         = hit && (wr_be[BE_CTL_LO] || wr_be[BE_CTL_HI]);
    ctl_we      = hit && wr_be[BE_CTL_LO];
    ctl_wval    = wr_data[FLAG_W:0];
    ilk_toggle  = hit && wr_be[BE_CTL_HI] && wr_data[ILK_BIT];
    sts_w1c     = (hit && wr_be[BE_STS_LO]) ? wr_data[STS_OFS +: FLAG_W] : '0;
  end

  assign unused_bits = ^{wr_be[3], wr_data[31:STS_OFS+FLAG_W],
                         wr_data[STS_OFS-1:ILK_BIT+1], wr_data[ILK_BIT-1:FLAG_W+1]};
endmodule

// File: rtl/hp_slot_regs.sv
`timescale 1ns/1ps
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  ctl_t              ctl_wval,
  input  logic              ilk_toggle,
  input  logic [FLAG_W-1:0] sts_w1c,
  input  logic [FLAG_W-1:0] flag_set,
  output ctl_t              ctl_q,
  output ctl_t              ctl_d,
  output sts_t              sts_q,
  output sts_t              sts_d
);
  logic ctl_en;
  logic sts_en;

  always_comb begin
    ctl_d      = ctl_we ? ctl_wval : ctl_q;
    // set after clear: a coinciding set wins
    sts_d.flag = (sts_q.flag & ~sts_w1c) | flag_set;
    sts_d.ilk  = sts_q.ilk ^ ilk_toggle;
    ctl_en     = ctl_we;
    sts_en     = ilk_toggle || (|sts_w1c) || (|flag_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (sts_en) sts_q <= sts_d;
    end
  end
endmodule

// File: rtl/hp_irq_gen.sv
`timescale 1ns/1ps
module hp_irq_gen
  import hp_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_enable,
  input  logic [FLAG_W-1:0] flag_set,
  input  ctl_t              ctl_q,
  input  ctl_t              ctl_d,
  input  logic [FLAG_W-1:0] flag_q,
  input  logic [FLAG_W-1:0] flag_d,
  output logic              msi_req,
  output logic              intx_level
);
  logic [FLAG_W-1:0]   en_rise;
  logic [HW_EVT_W-1:0] new_evt;
  logic                arm_hit;
  logic                cc_hit;
  logic                msi_d;
  logic                intx_d;

  always_comb begin
    en_rise = ctl_d.en & ~ctl_q.en;
    arm_hit = |(en_rise & flag_q);
    cc_hit  = flag_set[CC_BIT] && ctl_d.en[CC_BIT];
    new_evt = flag_set[HW_EVT_W-1:0] & ~flag_q[HW_EVT_W-1:0] & ctl_d.en[HW_EVT_W-1:0];
    msi_d   = msi_enable && ctl_d.hpie && (arm_hit || cc_hit || (|new_evt));
    intx_d  = !msi_enable && ctl_d.hpie && (|(ctl_d.en & flag_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_req    <= 1'b0;
      intx_level <= 1'b0;
    end else begin
      msi_req    <= msi_d;
      intx_level <= intx_d;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
`timescale 1ns/1ps
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int unsigned SLOT_DWORD = 32'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [3:0]        cfg_wr_be,
  input  logic [31:0]       cfg_wr_data,
  input  logic              msi_enable,
  input  logic [3:0]        hw_evt,
  output logic [31:0]       rd_data,
  output logic              interlock_state,
  output logic              intx_level,
  output logic              msi_req
);
  logic              rst_sync_n;
  logic              cmd;
  logic              ctl_we;
  ctl_t              ctl_wval;
  logic              ilk_toggle;
  logic [FLAG_W-1:0] sts_w1c;
  logic [FLAG_W-1:0] flag_set;
  ctl_t              ctl_q;
  ctl_t              ctl_d;
  sts_t              sts_q;
  sts_t              sts_d;

  hp_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  hp_cfg_decode #(.ADDR_W(ADDR_W), .SLOT_DWORD(SLOT_DWORD)) u_dec (
    .wr_en      (cfg_wr_en),
    .wr_addr    (cfg_wr_addr),
    .wr_be      (cfg_wr_be),
    .wr_data    (cfg_wr_data),
    .cmd        (cmd),
    .ctl_we     (ctl_we),
    .ctl_wval   (ctl_wval),
    .ilk_toggle (ilk_toggle),
    .sts_w1c    (sts_w1c)
  );

  assign flag_set = {cmd, hw_evt};

  hp_slot_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctl_we     (ctl_we),
    .ctl_wval   (ctl_wval),
    .ilk_toggle (ilk_toggle),
    .sts_w1c    (sts_w1c),
    .flag_set   (flag_set),
    .ctl_q      (ctl_q),
    .ctl_d      (ctl_d),
    .sts_q      (sts_q),
    .sts_d      (sts_d)
  );

  hp_irq_gen u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .msi_enable (msi_enable),
    .flag_set   (flag_set),
    .ctl_q      (ctl_q),
    .ctl_d      (ctl_d),
    .flag_q     (sts_q.flag),
    .flag_d     (sts_d.flag),
    .msi_req    (msi_req),
    .intx_level (intx_level)
  );

  logic unused_ilk_d;
  assign unused_ilk_d = sts_d.ilk;

  assign rd_data = {8'h00, sts_q.ilk, 2'b00, sts_q.flag, 10'h000, ctl_q};
  assign interlock_state = sts_q.ilk;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
`timescale 1ns/1ps
module hp_slot_ctrl_chk #(
  parameter int          ADDR_W     = 10,
  parameter int unsigned SLOT_DWORD = 32'h16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [ADDR_W-1:0] cfg_wr_addr,
  input logic [3:0]        cfg_wr_be,
  input logic [31:0]       cfg_wr_data,
  input logic              msi_enable,
  input logic [3:0]        hw_evt,
  input logic [31:0]       rd_data,
  input logic              interlock_state,
  input logic              intx_level,
  input logic              msi_req
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SLOT_DWORD);

  logic hit, cmd_seen, ilk_req;
  logic unused_chk;
  assign hit      = cfg_wr_en && (cfg_wr_addr == MATCH);
  assign cmd_seen = hit && (cfg_wr_be[0] || cfg_wr_be[1]);
  assign ilk_req  = hit && cfg_wr_be[1] && cfg_wr_data[11];
  assign unused_chk = ^{cfg_wr_be, cfg_wr_data};

  // R5: every command leaves command-completed set
  assert_cc_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seen |=> rd_data[20]);

  // R4: interlock request flips the state
  assert_ilk_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_req |=> (interlock_state != $past(interlock_state)));

  // R4: no request, no change
  assert_ilk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ilk_req |=> $stable(interlock_state));

  // R2: control bits only move on a low-byte write to the slot dword
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && cfg_wr_be[0]) |=> $stable(rd_data[5:0]));

  // R7: hardware events land in the status flags
  assert_evt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != 4'h0) |=> ((rd_data[19:16] & $past(hw_evt)) == $past(hw_evt)));

  // R10: no message request in wire mode
  assert_no_msi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_enable |=> !msi_req);

  // R10: wire level in message mode is low
  assert_no_intx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msi_enable |=> !intx_level);

  // R10: wire level tracks enabled pending flags
  assert_intx_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_enable |=> (intx_level == (rd_data[5] && (|(rd_data[4:0] & rd_data[20:16])))));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.ADDR_W(ADDR_W), .SLOT_DWORD(SLOT_DWORD)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .cfg_wr_en       (cfg_wr_en),
  .cfg_wr_addr     (cfg_wr_addr),
  .cfg_wr_be       (cfg_wr_be),
  .cfg_wr_data     (cfg_wr_data),
  .msi_enable      (msi_enable),
  .hw_evt          (hw_evt),
  .rd_data         (rd_data),
  .interlock_state (interlock_state),
  .intx_level      (intx_level),
  .msi_req         (msi_req)
);

// File: tb/hp_slot_ctrl_test.sv
`timescale 1ns/1ps
module hp_slot_ctrl_test;
  localparam int ADDR_W = 10;
  localparam int unsigned SLOT = 32'h16;
  localparam logic [ADDR_W-1:0] SA = ADDR_W'(SLOT);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_wr_en;
  logic [ADDR_W-1:0] cfg_wr_addr;
  logic [3:0]        cfg_wr_be;
  logic [31:0]       cfg_wr_data;
  logic              msi_enable;
  logic [3:0]        hw_evt;
  logic [31:0]       rd_data;
  logic              interlock_state, intx_level, msi_req;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [5:0] m_ctl;
  logic [4:0] m_sts;
  logic       m_ilk, m_msi, m_intx;

  always #10 clk = ~clk;   // 50 MHz

  hp_slot_ctrl #(.ADDR_W(ADDR_W), .SLOT_DWORD(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .msi_enable(msi_enable),
    .hw_evt(hw_evt), .rd_data(rd_data), .interlock_state(interlock_state),
    .intx_level(intx_level), .msi_req(msi_req)
  );

  function automatic logic [31:0] exp_word();
    return {8'h00, m_ilk, 2'b00, m_sts, 10'h000, m_ctl};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R3 rd_data"}, rd_data, exp_word());
    check({tag, " R4 interlock_state"}, {31'd0, interlock_state}, {31'd0, m_ilk});
    check({tag, " R10 intx_level"}, {31'd0, intx_level}, {31'd0, m_intx});
    check({tag, " R8 msi_req"}, {31'd0, msi_req}, {31'd0, m_msi});
  endtask

  // drive one cycle at the falling edge, predict, compare at the next falling edge
  task automatic apply(input string tag, input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [3:0] be, input logic [31:0] d,
                       input logic me, input logic [3:0] ev);
    logic       hit, cmd;
    logic [5:0] cn;
    logic [4:0] w1c, setv, sn;
    logic       iln, msin, intxn;
    cfg_wr_en = wr; cfg_wr_addr = a; cfg_wr_be = be; cfg_wr_data = d;
    msi_enable = me; hw_evt = ev;
    hit   = wr && (a == SA);
    cmd   = hit && (be[0] || be[1]);
    cn    = (hit && be[0]) ? d[5:0] : m_ctl;
    w1c   = (hit && be[2]) ? d[20:16] : 5'd0;
    setv  = {cmd, ev};
    sn    = (m_sts & ~w1c) | setv;
    iln   = m_ilk ^ (hit && be[1] && d[11]);
    msin  = me && cn[5] && ((|((cn[4:0] & ~m_ctl[4:0]) & m_sts)) || (cmd && cn[4]) ||
                            (|(ev & ~m_sts[3:0] & cn[3:0])));
    intxn = !me && cn[5] && (|(cn[4:0] & sn));
    @(posedge clk);
    @(negedge clk);
    m_ctl = cn; m_sts = sn; m_ilk = iln; m_msi = msin; m_intx = intxn;
    cfg_wr_en = 1'b0; hw_evt = 4'h0;
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all requirements: watchdog expired, actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_be = '0;
    cfg_wr_data = '0; msi_enable = 1'b0; hw_evt = '0;
    m_ctl = '0; m_sts = '0; m_ilk = 1'b0; m_msi = 1'b0; m_intx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset state");

    // wire-interrupt mode
    apply("R3 R5 low byte write",        1, SA,   4'b0001, 32'h0000_003F, 0, 4'h0);
    apply("R2 neighbour dword ignored",  1, SA+1, 4'b1111, 32'hFFFF_FFFF, 0, 4'h0);
    apply("R2 no strobe ignored",        0, SA,   4'b1111, 32'hFFFF_F7C0, 0, 4'h0);
    apply("R2 R6 status-only clear",     1, SA,   4'b0100, 32'h001F_0000, 0, 4'h0);
    apply("R4 interlock toggle on",      1, SA,   4'b0010, 32'h0000_0800, 0, 4'h0);
    apply("R4 interlock toggle off",     1, SA,   4'b0010, 32'h0000_0800, 0, 4'h0);
    apply("R6 clear completed",          1, SA,   4'b0100, 32'h0010_0000, 0, 4'h0);
    apply("R5 no-change command",        1, SA,   4'b0001, 32'h0000_003F, 0, 4'h0);
    apply("R6 set wins over clear",      1, SA,   4'b0100, 32'h001F_0000, 0, 4'h1);
    apply("R7 event inputs",             0, SA,   4'b0000, 32'h0,         0, 4'hA);
    apply("R10 disable hot-plug irq",    1, SA,   4'b0001, 32'h0000_001F, 0, 4'h0);

    // message-interrupt mode
    apply("R8 enables off",              1, SA,   4'b0001, 32'h0000_0000, 1, 4'h0);
    apply("R6 clear all",                1, SA,   4'b0100, 32'h001F_0000, 1, 4'h0);
    apply("R11 event while disabled",    0, SA,   4'b0000, 32'h0,         1, 4'h1);
    apply("R8 enable rises on pending",  1, SA,   4'b0001, 32'h0000_0021, 1, 4'h0);
    apply("R8 no rise no pulse",         1, SA,   4'b0001, 32'h0000_0021, 1, 4'h0);
    apply("R9 completed enable",         1, SA,   4'b0001, 32'h0000_0031, 1, 4'h0);
    apply("R9 repeat command",           1, SA,   4'b0010, 32'h0000_0000, 1, 4'h0);
    apply("R11 arm presence",            1, SA,   4'b0101, 32'h0008_0029, 1, 4'h0);
    apply("R11 presence event",          0, SA,   4'b0000, 32'h0,         1, 4'h8);
    apply("R11 event already pending",   0, SA,   4'b0000, 32'h0,         1, 4'h8);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [3:0] ev;
      logic me;
      int unsigned r;
      r  = $urandom % 4;
      a  = (r == 0) ? ADDR_W'($urandom) : ((r == 1) ? SA + 1'b1 : SA);
      ev = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
      me = ((i / 97) % 2) == 1;
      apply("R2 R3 R6 R7 random", 1'($urandom), a, 4'($urandom), $urandom, me, ev);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule